// File: doc/BRIEF.md
# Multi-Sample IQ Frame Multiplexer

This block gathers I/Q samples from up to eight antenna-carrier channels and packs them into the IQ payload of a fixed-length basic frame. The frame goes out as a stream of 16-bit words, one word per clock. A start pulse from the link layer marks the basic frame period. The multiplexer answers it by opening a data-enable window for every active channel. The window lasts as many cycles as that channel's sample count. On each enabled cycle the channel's source presents one I/Q pair, and the block captures it. Everything collected in one frame period is sent in the following basic frame.

By default a frame is eight words long. Word 0 is the control word, which this block sends as zero. Words 1 to 7 carry a 112-bit payload. The samples are flattened in this order: by channel, then by sample, with I before Q. Bits are packed from the LSB and run across word boundaries without gaps. Channel count, sample counts and widths are fixed at elaboration. Elaboration stops on a configuration that cannot work:
- more samples than the frame length minus one,
- a width outside 4 to 20,
- a total that does not fit the payload.

Top module: `iq_frame_mux`

## Requirements
- R1: After reset, and until the first start pulse, every data-enable output is low, the frame-start output is low and the output word is zero.
- R2: The cycle after a start pulse, the frame-start output is high and the output word is zero (control word). Frames then repeat every FRAME_WORDS cycles, with frame-start high on word 0 only, even if no further pulse arrives.
- R3: Channel c's data-enable is high on exactly the first CH_SAMPLES[c] cycles of each frame, starting at word 0. An inactive channel (zero samples) never asserts it.
- R4: On the k-th enabled cycle of channel c (k counting from 0), the block captures that cycle's I and Q as sample k. Only the low CH_WIDTH[c] bits of each input lane of MAX_W (20) bits are used.
- R5: The samples captured in one frame appear in the next frame's words 1 to FRAME_WORDS-1. Payload bit b is output word 1+b/16, bit b%16.
- R6: The payload order is ascending channel, then ascending sample, with I bits then Q bits, each value LSB first. Inactive channels take no bits.
- R7: Payload bits beyond the sum of 2*CH_SAMPLES[c]*CH_WIDTH[c] are always zero.
- R8: Input values on cycles outside a channel's window have no effect on any emitted word. A stored sample keeps its value until its own window overwrites it.
- R9: A start pulse in the middle of a frame makes the next cycle word 0 of a new frame. The interrupted frame's samples are not emitted, and the next frame repeats the last completed payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start_i | input | 1 | Frame start pulse; the next cycle is word 0 |
| samp_i_i | input | NUM_CH*20 | I sample lanes, channel c at bits [c*20 +: 20] |
| samp_q_i | input | NUM_CH*20 | Q sample lanes, same layout as samp_i_i |
| samp_en_o | output | NUM_CH | Per-channel data-enable window |
| tx_word_o | output | WORD_W | Outgoing frame word |
| tx_frame_start_o | output | 1 | High while word 0 of a frame is on tx_word_o |

## Verification
The bench builds the block with four channel configurations:
- channel 0 with seven 4-bit samples, which is the largest legal count;
- channel 1 with one 20-bit sample, which is the widest legal lane;
- channel 2 inactive, which leaves a gap that must take no payload space;
- channel 3 with one 4-bit sample.

These use 104 of the 112 payload bits. The setup therefore covers the longest enable window, a full-width lane, skipping of an inactive channel, and a zero tail that spans part of the last word. Random lane values are driven on every cycle, including cycles outside the windows and bits above each width. All-ones and all-zeros frames, a mid-frame restart and free-running frames without pulses are added on top.

// File: rtl/iqm_pkg.sv
// Package: shared limits, configuration array type and payload layout helpers
// for the multi-sample IQ frame multiplexer.
package iqm_pkg;

    localparam int unsigned MAX_CH = 8;   // channel slots available
    localparam int unsigned MAX_W  = 20;  // widest legal I or Q value
    localparam int unsigned MIN_W  = 4;   // narrowest legal I or Q value

    // One entry per channel slot; zero marks an inactive channel.
    typedef int unsigned ch_cfg_t [MAX_CH];

    // Bits one channel occupies in the payload (I and Q for every sample).
    function automatic int unsigned chan_bits(int unsigned samples, int unsigned width);
        return 2 * samples * width;
    endfunction

    // First payload bit of channel ch: sum of all lower channels' bits.
    function automatic int unsigned chan_base(ch_cfg_t samples, ch_cfg_t width, int unsigned ch);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < MAX_CH; k++) begin
            if (k < ch) acc += chan_bits(samples[k], width[k]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/iqm_frame_timer.sv
// Module: iqm_frame_timer
// Tracks the word position inside the basic frame. A start pulse forces the
// next cycle to word 0. Without pulses the counter wraps on its own every
// FRAME_WORDS cycles. Nothing is reported until the first pulse arrives.
// Assumes: the start pulse is one cycle wide.
module iqm_frame_timer #(
    parameter int unsigned FRAME_WORDS = 8,
    parameter int unsigned PHASE_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               running_o,
    output logic               first_o,
    output logic               last_o
);

    localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(FRAME_WORDS - 1);

    logic [PHASE_W-1:0] phase_q;
    logic               running_q;

    // Word position counter: realign on a pulse, else wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= '0;
            running_q <= 1'b0;
        end else if (start_i) begin
            phase_q   <= '0;
            running_q <= 1'b1;
        end else if (running_q) begin
            phase_q   <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
        end
    end

    assign phase_o   = phase_q;
    assign running_o = running_q;
    assign first_o   = running_q && (phase_q == '0);
    assign last_o    = running_q && (phase_q == LAST_PH);

    AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> first_o); // R9

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> first_o); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !start_i && phase_q != LAST_PH) |=> (phase_q == $past(phase_q) + 1'b1)); // R2

endmodule

// File: rtl/iqm_chan_capture.sv
// Module: iqm_chan_capture
// Owns one active channel. It opens the data-enable window for the first
// SAMPLES words of each frame and stores the I/Q pair of enabled cycle k
// into sub-slot k. It presents its slot, placed at BASE, inside an
// otherwise-zero payload vector.
// Assumes: 1 <= SAMPLES <= frame words - 1 and BASE + slot fits the payload.
module iqm_chan_capture #(
    parameter int unsigned SAMPLES      = 1,
    parameter int unsigned WIDTH        = 4,
    parameter int unsigned BASE         = 0,
    parameter int unsigned PAYLOAD_BITS = 112,
    parameter int unsigned PHASE_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    running_i,
    input  logic [PHASE_W-1:0]      phase_i,
    input  logic [WIDTH-1:0]        i_i,
    input  logic [WIDTH-1:0]        q_i,
    output logic                    en_o,
    output logic [PAYLOAD_BITS-1:0] part_o
);

    localparam int unsigned SLOT_W = 2 * SAMPLES * WIDTH;
    localparam int unsigned PAIR_W = 2 * WIDTH;

    logic [SLOT_W-1:0] slot_q;

    // Window: the first SAMPLES words of every running frame.
    assign en_o = running_i && (phase_i < PHASE_W'(SAMPLES));

    // Capture: the word position selects the sub-slot, I in the low half, Q above.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (en_o) begin
            for (int s = 0; s < SAMPLES; s++) begin
                if (phase_i == PHASE_W'(s)) begin
                    slot_q[s*PAIR_W +: WIDTH]         <= i_i;
                    slot_q[s*PAIR_W + WIDTH +: WIDTH] <= q_i;
                end
            end
        end
    end

    // Placement: slot at its base, every other bit zero.
    always_comb begin
        part_o = '0;
        part_o[BASE +: SLOT_W] = slot_q;
    end

    AST_WINDOW_OPENS_AT_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> (phase_i == '0)); // R3

    AST_SLOT_HELD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> $stable(slot_q)); // R8

endmodule

// File: rtl/iqm_payload_out.sv
// Module: iqm_payload_out
// Holds the payload of the last completed frame and serialises it. Word 0
// is the zero control word, and word k carries payload bits
// [(k-1)*WORD_W +: WORD_W].
// Assumes: load_i pulses on the last word of each completed frame.
module iqm_payload_out #(
    parameter int unsigned PAYLOAD_BITS = 112,
    parameter int unsigned WORD_W       = 16,
    parameter int unsigned FRAME_WORDS  = 8,
    parameter int unsigned PHASE_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    running_i,
    input  logic [PHASE_W-1:0]      phase_i,
    input  logic [PAYLOAD_BITS-1:0] payload_i,
    output logic [WORD_W-1:0]       word_o
);

    logic [PAYLOAD_BITS-1:0] shadow_q;
    logic [WORD_W-1:0]       words [FRAME_WORDS];

    // Shadow: take the collected payload at the close of a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else if (load_i) shadow_q <= payload_i;
    end

    // Word map: zero control word, then the payload slices in order.
    assign words[0] = '0;
    for (genvar k = 1; k < FRAME_WORDS; k++) begin : g_word
        assign words[k] = shadow_q[(k-1)*WORD_W +: WORD_W];
    end

    // Output select: silent until frames run.
    assign word_o = running_i ? words[phase_i] : '0;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(shadow_q)); // R5

endmodule

// File: rtl/iq_frame_mux.sv
// Module: iq_frame_mux (top)
// Multi-sample IQ frame multiplexer. A frame timer, one capture unit per
// active channel and a payload serialiser. The capture units' slots are
// OR-merged into one payload. Each slot is zero outside its own range, so
// the merge is a plain concatenation.
// Assumes: configuration legal (checked at elaboration), start pulse one
// cycle wide.
module iq_frame_mux
    import iqm_pkg::*;
#(
    parameter int unsigned FRAME_WORDS = 8,
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned NUM_CH      = 8,
    parameter ch_cfg_t     CH_SAMPLES  = '{3, 2, 0, 0, 0, 0, 0, 0},
    parameter ch_cfg_t     CH_WIDTH    = '{14, 6, 0, 0, 0, 0, 0, 0}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_start_i,
    input  logic [NUM_CH*MAX_W-1:0] samp_i_i,
    input  logic [NUM_CH*MAX_W-1:0] samp_q_i,
    output logic [NUM_CH-1:0]       samp_en_o,
    output logic [WORD_W-1:0]       tx_word_o,
    output logic                    tx_frame_start_o
);

    localparam int unsigned PAYLOAD_BITS = (FRAME_WORDS - 1) * WORD_W;
    localparam int unsigned PHASE_W      = (FRAME_WORDS > 2) ? $clog2(FRAME_WORDS) : 1;
    localparam int unsigned TOTAL_BITS   = chan_base(CH_SAMPLES, CH_WIDTH, MAX_CH);

    // Elaboration checks on the configuration.
    if (NUM_CH > MAX_CH || NUM_CH == 0) begin : g_bad_count
        $error("iq_frame_mux: NUM_CH must be 1..%0d", MAX_CH);
    end
    if (TOTAL_BITS > PAYLOAD_BITS) begin : g_bad_total
        $error("iq_frame_mux: %0d sample bits exceed %0d payload bits", TOTAL_BITS, PAYLOAD_BITS);
    end
    for (genvar c = 0; c < MAX_CH; c++) begin : g_cfg_chk
        if (CH_SAMPLES[c] == 0) begin : g_off
            if (CH_WIDTH[c] != 0) begin : g_w
                $error("iq_frame_mux: inactive channel %0d needs width 0", c);
            end
        end else begin : g_on
            if (c >= NUM_CH) begin : g_range
                $error("iq_frame_mux: channel %0d lies beyond NUM_CH", c);
            end
            if (CH_SAMPLES[c] > FRAME_WORDS - 1) begin : g_s
                $error("iq_frame_mux: channel %0d sample count too large", c);
            end
            if (CH_WIDTH[c] < MIN_W || CH_WIDTH[c] > MAX_W) begin : g_w
                $error("iq_frame_mux: channel %0d width outside %0d..%0d", c, MIN_W, MAX_W);
            end
        end
    end

    logic [PHASE_W-1:0]      phase;
    logic                    running;
    logic                    first_word;
    logic                    last_word;
    logic [PAYLOAD_BITS-1:0] part  [NUM_CH];
    logic [PAYLOAD_BITS-1:0] merge [NUM_CH+1];
    logic                    unused_lanes;

    // Lane bits above each width are ignored on purpose.
    assign unused_lanes = ^{samp_i_i, samp_q_i};

    iqm_frame_timer #(
        .FRAME_WORDS (FRAME_WORDS),
        .PHASE_W     (PHASE_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tx_start_i),
        .phase_o   (phase),
        .running_o (running),
        .first_o   (first_word),
        .last_o    (last_word)
    );

    // One capture unit per active channel; inactive slots stay silent.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (CH_SAMPLES[c] != 0) begin : g_act
            iqm_chan_capture #(
                .SAMPLES      (CH_SAMPLES[c]),
                .WIDTH        (CH_WIDTH[c]),
                .BASE         (chan_base(CH_SAMPLES, CH_WIDTH, c)),
                .PAYLOAD_BITS (PAYLOAD_BITS),
                .PHASE_W      (PHASE_W)
            ) u_cap (
                .clk       (clk),
                .rst_n     (rst_n),
                .running_i (running),
                .phase_i   (phase),
                .i_i       (samp_i_i[c*MAX_W +: CH_WIDTH[c]]),
                .q_i       (samp_q_i[c*MAX_W +: CH_WIDTH[c]]),
                .en_o      (samp_en_o[c]),
                .part_o    (part[c])
            );
        end else begin : g_idle
            assign samp_en_o[c] = 1'b0;
            assign part[c]      = '0;
        end
        assign merge[c+1] = merge[c] | part[c];
    end
    assign merge[0] = '0;

    iqm_payload_out #(
        .PAYLOAD_BITS (PAYLOAD_BITS),
        .WORD_W       (WORD_W),
        .FRAME_WORDS  (FRAME_WORDS),
        .PHASE_W      (PHASE_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (last_word),
        .running_i (running),
        .phase_i   (phase),
        .payload_i (merge[NUM_CH]),
        .word_o    (tx_word_o)
    );

    assign tx_frame_start_o = first_word;

    AST_CTRL_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_start_o |-> (tx_word_o == '0)); // R2

    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (samp_en_o == '0 && tx_word_o == '0)); // R1

endmodule

// File: tb/iq_frame_mux_test.sv
// Bench for iq_frame_mux: random lanes from a fixed seed plus directed frames.
// The expected payload is rebuilt from the requirements by pack_payload().
module iq_frame_mux_test;
    import iqm_pkg::*;

    localparam int          NCH = 8;
    localparam int          FW  = 8;
    localparam int          WW  = 16;
    localparam int          PB  = (FW - 1) * WW;
    localparam int          LW  = MAX_W;
    localparam ch_cfg_t     TS  = '{7, 1, 0, 1, 0, 0, 0, 0};
    localparam ch_cfg_t     TW  = '{4, 20, 0, 4, 0, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NCH*LW-1:0] si = '0;
    logic [NCH*LW-1:0] sq = '0;
    logic [NCH-1:0]    en;
    logic [WW-1:0]     word;
    logic              fs;

    int      total = 0;
    int      bad = 0;
    bit      done = 1'b0;
    logic [PB-1:0] shown = '0;
    logic [LW-1:0] cap_i [NCH][FW];
    logic [LW-1:0] cap_q [NCH][FW];

    always #5 clk = ~clk;

    iq_frame_mux #(
        .FRAME_WORDS (FW),
        .WORD_W      (WW),
        .NUM_CH      (NCH),
        .CH_SAMPLES  (TS),
        .CH_WIDTH    (TW)
    ) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .tx_start_i       (start),
        .samp_i_i         (si),
        .samp_q_i         (sq),
        .samp_en_o        (en),
        .tx_word_o        (word),
        .tx_frame_start_o (fs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R6 order: channel, sample, I then Q, LSB first, inactive channels skipped.
    function automatic logic [PB-1:0] pack_payload();
        logic [PB-1:0] r;
        int pos;
        r = '0;
        pos = 0;
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < int'(TS[c]); s++) begin
                for (int b = 0; b < int'(TW[c]); b++) begin
                    r[pos] = cap_i[c][s][b];
                    pos = pos + 1;
                end
                for (int b = 0; b < int'(TW[c]); b++) begin
                    r[pos] = cap_q[c][s][b];
                    pos = pos + 1;
                end
            end
        end
        return r;
    endfunction

    // One frame from word 0. mode: 0 random, 1 all ones, 2 all zeros.
    // abort_at >= 0 restarts mid-frame; chain raises start on the last word.
    task automatic run_frame(input int mode, input int abort_at, input bit chain);
        logic [LW-1:0] vi;
        logic [LW-1:0] vq;
        for (int p = 0; p < FW; p++) begin
            @(negedge clk);
            chk("R2 R9 frame start marker", {31'b0, fs}, {31'b0, p == 0});
            if (p == 0) chk("R2 control word zero", {16'b0, word}, 32'h0);
            else chk("R5 R6 R4 R8 payload word", {16'b0, word}, {16'b0, shown[(p-1)*WW +: WW]});
            if (p == FW - 1) chk("R7 unused tail bits", {24'b0, word[15:8]}, 32'h0);
            for (int c = 0; c < NCH; c++) begin
                chk("R3 enable window", {31'b0, en[c]}, {31'b0, p < int'(TS[c])});
                vi = (mode == 1) ? '1 : (mode == 2) ? '0 : LW'($urandom);
                vq = (mode == 1) ? '1 : (mode == 2) ? '0 : LW'($urandom);
                si[c*LW +: LW] = vi;
                sq[c*LW +: LW] = vq;
                if (p < int'(TS[c])) begin
                    cap_i[c][p] = vi;
                    cap_q[c][p] = vq;
                end
            end
            if (p == abort_at) begin
                start = 1'b1;
                return;
            end
            start = (p == FW - 1) && chain;
        end
        shown = pack_payload();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd2024);
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < FW; s++) begin
                cap_i[c][s] = '0;
                cap_q[c][s] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet before the first start pulse, even with busy lanes.
        for (int k = 0; k < 4; k++) begin
            si = {NCH{LW'($urandom)}};
            sq = {NCH{LW'($urandom)}};
            @(negedge clk);
            chk("R1 idle enables", {24'b0, en}, 32'h0);
            chk("R1 idle frame start", {31'b0, fs}, 32'h0);
            chk("R1 idle word", {16'b0, word}, 32'h0);
        end
        start = 1'b1;
        run_frame(0, -1, 1'b1);          // emits the reset payload (zero)
        for (int f = 0; f < 5; f++) run_frame(0, -1, 1'b1);
        run_frame(1, -1, 1'b1);          // all ones: fills every used bit
        run_frame(2, -1, 1'b1);          // all zeros, shows the all-ones frame
        run_frame(0, -1, 1'b1);
        run_frame(0, 3, 1'b1);           // R9: restart at word 3
        run_frame(0, -1, 1'b1);          // repeats last completed payload
        run_frame(0, -1, 1'b0);          // no pulse on the last word
        run_frame(0, -1, 1'b0);          // R2: free-running frame
        run_frame(1, -1, 1'b0);
        run_frame(0, -1, 1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule